// File: doc/BRIEF.md
# Stop-Mode Wakeup and Recovery Controller

This block supervises a microcontroller's deepest power-down state. On a request from the CPU it gates the system clock off, then watches six wake causes: a low level on the reset pin, a low-supply indication, a falling edge on the interrupt pin, a falling edge on any keyboard line, a debug break request and a rollover of an internal timebase counter. The winning cause selects the vector address the CPU fetches first once it runs again.

For every cause except the timebase, the clock stays gated for a fixed stabilisation window that is counted on the reference clock; a timebase wake can only happen while the oscillator already runs, so its clock is released at once. The timebase counts through stop only when the oscillator-in-stop configuration bit is set. CPU access to the timebase register is refused while the core is waiting or stopped.

Top module: `stopwake_ctrl`

## Requirements
- R1: During and right after reset, clk_en is 1, vec_valid is 0, vec_addr is 16'h0000 and wake_done is 0.
- R2: A stop_req sampled while the clock runs makes clk_en 0 from the next cycle; with no wake cause it stays 0.
- R3: A low reset_pin_n or a high supply_low during stop selects vec_addr 16'hFFFE.
- R4: A high-to-low change on irq_pin during stop, seen after a two-stage synchroniser, selects 16'hFFFA.
- R5: A high-to-low change on any kbd_pins line during stop selects 16'hFFDE.
- R6: brk_req high during stop selects 16'hFFFC.
- R7: With tb_on and osc_in_stop both 1, a timebase rollover during stop selects 16'hFFDC and restores clk_en on the same edge that raises vec_valid.
- R8: With osc_in_stop 0, tb_running is 0 while stopped and the timebase never wakes the block.
- R9: For causes other than the timebase, clk_en stays 0 for exactly RECOV_CYCLES (default 4096) cycles after vec_valid rises; wake_done is a one-cycle pulse in the first cycle clk_en is 1 again.
- R10: Causes present in the same cycle are ranked reset/supply, break, interrupt pin, keyboard, timebase; only the highest one's vector appears.
- R11: vec_addr holds steady while vec_valid is 1 and is cleared from vec_valid the cycle after vec_ack.
- R12: A stop_req arriving while the recovery count runs is dropped; the clock comes back and stays on.
- R13: tb_acc_ok is 1 only when tb_acc_req is 1, the clock runs and wait_mode is 0.
- R14: Wake inputs that change while the clock runs leave vec_addr and vec_valid untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | CPU request to enter stop |
| wait_mode | input | 1 | CPU is in wait |
| reset_pin_n | input | 1 | External reset pin, active low, asynchronous |
| supply_low | input | 1 | Supply below threshold, asynchronous |
| irq_pin | input | 1 | External interrupt pin, asynchronous |
| kbd_pins | input | KBD_W | Keyboard interrupt lines, asynchronous |
| brk_req | input | 1 | Debug break request |
| osc_in_stop | input | 1 | Configuration: oscillator keeps running in stop |
| tb_on | input | 1 | Timebase enabled by software |
| tb_acc_req | input | 1 | CPU access to the timebase register |
| vec_ack | input | 1 | CPU has taken the vector |
| clk_en | output | 1 | System clock enable |
| wake_done | output | 1 | Pulse when the clock is released |
| vec_valid | output | 1 | vec_addr holds a pending vector |
| vec_addr | output | 16 | Address of the vector pair to fetch |
| tb_running | output | 1 | Timebase counter is advancing |
| tb_acc_ok | output | 1 | Timebase register access granted |

## Verification
Two wake causes can land in one cycle because the interrupt pin and the keyboard lines share one synchroniser timing, and the reset pin travels through a synchroniser of the same depth. The bench drops the interrupt pin and a keyboard line on the same edge, and separately lowers the reset pin together with an interrupt-pin fall, then judges the result by the vector the block presents: 16'hFFFA and 16'hFFFE respectively. A second overlap, a stop request landing mid-recovery, is judged by the clock staying on after release.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOP    = 2'd1,
        ST_RECOVER = 2'd2
    } pwr_state_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_RESET = 3'd1,
        SRC_BREAK = 3'd2,
        SRC_IRQ   = 3'd3,
        SRC_KBD   = 3'd4,
        SRC_TBASE = 3'd5
    } wake_src_e;

    typedef struct packed {
        logic rst_lvl;
        logic brk;
        logic irq_fall;
        logic kbd_fall;
        logic tb_roll;
    } wake_req_t;

    localparam logic [15:0] VEC_RESET = 16'hFFFE;
    localparam logic [15:0] VEC_BREAK = 16'hFFFC;
    localparam logic [15:0] VEC_IRQ   = 16'hFFFA;
    localparam logic [15:0] VEC_KBD   = 16'hFFDE;
    localparam logic [15:0] VEC_TBASE = 16'hFFDC;

    function automatic logic [15:0] vector_of(input wake_src_e src);
        logic [15:0] v;
        case (src)
            SRC_RESET: v = VEC_RESET;
            SRC_BREAK: v = VEC_BREAK;
            SRC_IRQ:   v = VEC_IRQ;
            SRC_KBD:   v = VEC_KBD;
            SRC_TBASE: v = VEC_TBASE;
            default:   v = 16'h0000;
        endcase
        return v;
    endfunction

    function automatic logic needs_recovery(input wake_src_e src);
        return (src != SRC_TBASE) && (src != SRC_NONE);
    endfunction

endpackage

// File: rtl/stopwake_sync.sv
module stopwake_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/stopwake_fall.sv
module stopwake_fall #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    output logic [W-1:0] fall
);
    localparam logic [W-1:0] IDLE = '1;

    logic [W-1:0] cur;
    logic [W-1:0] prev;

    stopwake_sync #(.W(W), .STAGES(STAGES), .RST_VAL(IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins),
        .q   (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= IDLE;
        else     prev <= cur;
    end

    assign fall = prev & ~cur;
endmodule

// File: rtl/stopwake_prio.sv
module stopwake_prio
    import stopwake_pkg::*;
(
    input  wake_req_t req,
    output wake_src_e src
);
    always_comb begin
        if (req.rst_lvl)       src = SRC_RESET;
        else if (req.brk)      src = SRC_BREAK;
        else if (req.irq_fall) src = SRC_IRQ;
        else if (req.kbd_fall) src = SRC_KBD;
        else if (req.tb_roll)  src = SRC_TBASE;
        else                   src = SRC_NONE;
    end
endmodule

// File: rtl/stopwake_timebase.sv
module stopwake_timebase #(
    parameter int TB_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic roll
);
    logic [TB_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (run) count <= count + 1'b1;
    end

    assign roll = run && (&count);
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
    import stopwake_pkg::*;
#(
    parameter int KBD_W        = 4,
    parameter int TB_W         = 8,
    parameter int RECOV_CYCLES = 4096,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req,
    input  logic             wait_mode,
    input  logic             reset_pin_n,
    input  logic             supply_low,
    input  logic             irq_pin,
    input  logic [KBD_W-1:0] kbd_pins,
    input  logic             brk_req,
    input  logic             osc_in_stop,
    input  logic             tb_on,
    input  logic             tb_acc_req,
    input  logic             vec_ack,
    output logic             clk_en,
    output logic             wake_done,
    output logic             vec_valid,
    output logic [15:0]      vec_addr,
    output logic             tb_running,
    output logic             tb_acc_ok
);
    localparam int              CNT_W = (RECOV_CYCLES > 2) ? $clog2(RECOV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOV_CYCLES - 1);
    localparam int              EW    = KBD_W + 1;

    pwr_state_e       state;
    logic [CNT_W-1:0] rcnt;
    logic [1:0]       lvl_s;
    logic [EW-1:0]    falls;
    logic             tb_roll;
    wake_req_t        req;
    wake_src_e        src;

    // level causes: {reset_pin_n, supply_low}, idle values 1 and 0
    stopwake_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_lvl (
        .clk (clk),
        .rst (rst),
        .d   ({reset_pin_n, supply_low}),
        .q   (lvl_s)
    );

    stopwake_fall #(.W(EW), .STAGES(SYNC_STAGES)) u_fall (
        .clk  (clk),
        .rst  (rst),
        .pins ({irq_pin, kbd_pins}),
        .fall (falls)
    );

    assign tb_running = tb_on && ((state == ST_RUN) || osc_in_stop);

    stopwake_timebase #(.TB_W(TB_W)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .run  (tb_running),
        .roll (tb_roll)
    );

    always_comb begin
        req.rst_lvl  = ~lvl_s[1] | lvl_s[0];
        req.brk      = brk_req;
        req.irq_fall = falls[EW-1];
        req.kbd_fall = |falls[KBD_W-1:0];
        req.tb_roll  = tb_roll;
    end

    stopwake_prio u_prio (
        .req (req),
        .src (src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            rcnt      <= '0;
            vec_valid <= 1'b0;
            vec_addr  <= 16'h0000;
            wake_done <= 1'b0;
        end else begin
            wake_done <= 1'b0;
            if (vec_ack) vec_valid <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (stop_req) state <= ST_STOP;
                end
                ST_STOP: begin
                    if (src != SRC_NONE) begin
                        vec_addr  <= vector_of(src);
                        vec_valid <= 1'b1;
                        if (needs_recovery(src)) begin
                            state <= ST_RECOVER;
                            rcnt  <= '0;
                        end else begin
                            state     <= ST_RUN;
                            wake_done <= 1'b1;
                        end
                    end
                end
                ST_RECOVER: begin
                    if (rcnt == LAST) begin
                        state     <= ST_RUN;
                        wake_done <= 1'b1;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign clk_en    = (state == ST_RUN);
    assign tb_acc_ok = tb_acc_req && clk_en && !wait_mode;
endmodule

// File: rtl/stopwake_ctrl_chk.sv
module stopwake_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        stop_req,
    input logic        osc_in_stop,
    input logic        vec_ack,
    input logic        clk_en,
    input logic        wake_done,
    input logic        vec_valid,
    input logic [15:0] vec_addr,
    input logic        tb_running,
    input logic        tb_acc_ok
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (clk_en && !vec_valid && !wake_done && vec_addr == 16'h0000));

    assert_clock_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_en && stop_req) |=> !clk_en);

    assert_vector_legal_R3: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_addr == 16'hFFFE || vec_addr == 16'hFFFC ||
                       vec_addr == 16'hFFFA || vec_addr == 16'hFFDE ||
                       vec_addr == 16'hFFDC));

    assert_frozen_timebase_R8: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !osc_in_stop) |-> !tb_running);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        wake_done |=> !wake_done);

    assert_done_with_clock_R9: assert property (@(posedge clk) disable iff (rst)
        wake_done |-> clk_en);

    assert_release_signalled_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> wake_done);

    assert_vector_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ack && clk_en) |=> $stable(vec_addr));

    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && clk_en) |=> !vec_valid);

    assert_access_blocked_R13: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> !tb_acc_ok);
endmodule

bind stopwake_ctrl stopwake_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .osc_in_stop (osc_in_stop),
    .vec_ack     (vec_ack),
    .clk_en      (clk_en),
    .wake_done   (wake_done),
    .vec_valid   (vec_valid),
    .vec_addr    (vec_addr),
    .tb_running  (tb_running),
    .tb_acc_ok   (tb_acc_ok)
);

// File: tb/stopwake_ctrl_test.sv
`timescale 1ns/1ps
module stopwake_ctrl_test;
    localparam int KBD_W = 4;
    localparam int RECOV = 4096;
    localparam int NVEC  = 7;

    // kinds: 0 reset pin, 1 supply, 2 irq, 3 kbd line 0, 4 kbd line 3, 5 break, 6 timebase
    localparam int          KIND [NVEC] = '{0, 1, 2, 3, 4, 5, 6};
    localparam logic [15:0] EXPV [NVEC] = '{16'hFFFE, 16'hFFFE, 16'hFFFA, 16'hFFDE,
                                            16'hFFDE, 16'hFFFC, 16'hFFDC};
    localparam int          EXPD [NVEC] = '{RECOV, RECOV, RECOV, RECOV, RECOV, RECOV, 0};

    logic clk = 0;
    logic rst = 1;
    logic stop_req = 0, wait_mode = 0, reset_pin_n = 1, supply_low = 0, irq_pin = 1;
    logic [KBD_W-1:0] kbd_pins = '1;
    logic brk_req = 0, osc_in_stop = 0, tb_on = 0, tb_acc_req = 0, vec_ack = 0;
    logic clk_en, wake_done, vec_valid, tb_running, tb_acc_ok;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stopwake_ctrl #(.KBD_W(KBD_W), .RECOV_CYCLES(RECOV)) uut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wait_mode(wait_mode),
        .reset_pin_n(reset_pin_n), .supply_low(supply_low), .irq_pin(irq_pin),
        .kbd_pins(kbd_pins), .brk_req(brk_req), .osc_in_stop(osc_in_stop),
        .tb_on(tb_on), .tb_acc_req(tb_acc_req), .vec_ack(vec_ack),
        .clk_en(clk_en), .wake_done(wake_done), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .tb_running(tb_running), .tb_acc_ok(tb_acc_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic enter_stop();
        stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        check("R2 clock gated", clk_en, 0);
    endtask

    task automatic apply(input int kind);
        case (kind)
            0: reset_pin_n = 0;
            1: supply_low = 1;
            2: irq_pin = 0;
            3: kbd_pins[0] = 0;
            4: kbd_pins[3] = 0;
            5: brk_req = 1;
            default: begin tb_on = 1; osc_in_stop = 1; end
        endcase
    endtask

    task automatic idle_inputs();
        reset_pin_n = 1; supply_low = 0; irq_pin = 1; kbd_pins = '1;
        brk_req = 0; tb_on = 0; osc_in_stop = 0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 1000 && !vec_valid; i++) @(negedge clk);
    endtask

    // counts the samples with the clock still gated, from the first sample showing vec_valid
    task automatic count_gated(output int n);
        n = 0;
        while (!clk_en && n < RECOV + 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic ack();
        vec_ack = 1;
        @(negedge clk);
        vec_ack = 0;
        check("R11 ack clears valid", vec_valid, 0);
    endtask

    initial begin
        tick(3);
        check("R1 clk_en", clk_en, 1);
        check("R1 vec_valid", vec_valid, 0);
        check("R1 vec_addr", vec_addr, 0);
        check("R1 wake_done", wake_done, 0);
        rst = 0;
        tick(3);
        check("R1 after release", {clk_en, vec_valid, wake_done}, 3'b100);

        // R3 R4 R5 R6 R7 R9 table walk
        for (int k = 0; k < NVEC; k++) begin
            int n;
            enter_stop();
            tick(5);
            check("R2 stays gated", clk_en, 0);
            apply(KIND[k]);
            wait_valid();
            check("R3-R7 vector", vec_addr, EXPV[k]);
            count_gated(n);
            check("R9 gated cycles", n, EXPD[k]);
            check("R9 wake_done", wake_done, 1);
            idle_inputs();
            @(negedge clk);
            check("R9 single pulse", wake_done, 0);
            ack();
            tick(4);
        end

        // R8: oscillator off in stop freezes the timebase
        begin
            int n;
            tb_on = 1; osc_in_stop = 0;
            @(negedge clk);
            check("R8 runs when clocked", tb_running, 1);
            enter_stop();
            check("R8 frozen", tb_running, 0);
            tick(600);
            check("R8 no wake", {vec_valid, clk_en}, 2'b00);
            tb_on = 0;
            apply(5);
            wait_valid();
            check("R6 break after frozen", vec_addr, 16'hFFFC);
            count_gated(n);
            idle_inputs();
            ack();
        end

        // R10: interrupt pin and keyboard fall together
        begin
            int n;
            enter_stop();
            irq_pin = 0; kbd_pins[1] = 0;
            wait_valid();
            check("R10 irq over kbd", vec_addr, 16'hFFFA);
            count_gated(n);
            idle_inputs();
            ack();
            tick(4);
        end

        // R10: reset pin with interrupt pin
        begin
            int n;
            enter_stop();
            reset_pin_n = 0; irq_pin = 0;
            wait_valid();
            check("R10 reset over irq", vec_addr, 16'hFFFE);
            count_gated(n);
            idle_inputs();
            ack();
            tick(4);
        end

        // R12: stop request during recovery is dropped; R11/R14 hold without ack
        begin
            int n;
            logic stayed;
            enter_stop();
            brk_req = 1;
            wait_valid();
            brk_req = 0;
            tick(100);
            stop_req = 1;
            @(negedge clk);
            stop_req = 0;
            count_gated(n);
            check("R12 recovery not restarted", n, RECOV - 101);
            stayed = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!clk_en) stayed = 0;
            end
            check("R12 clock stays on", stayed, 1);
            brk_req = 1; irq_pin = 0; kbd_pins[2] = 0;
            tick(10);
            check("R14 vector kept", vec_addr, 16'hFFFC);
            check("R11 valid until ack", vec_valid, 1);
            idle_inputs();
            ack();
        end

        // R13: timebase register access gating
        tb_acc_req = 1;
        @(negedge clk);
        check("R13 granted", tb_acc_ok, 1);
        wait_mode = 1;
        @(negedge clk);
        check("R13 blocked in wait", tb_acc_ok, 0);
        wait_mode = 0;
        enter_stop();
        check("R13 blocked in stop", tb_acc_ok, 0);
        brk_req = 1;
        wait_valid();
        brk_req = 0;
        tb_acc_req = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule